// File: doc/BRIEF.md
# Slow-Clock System Timer

A memory-mapped system timer driven by a single-cycle enable that pulses at the 32768 Hz slow-clock rate. It has three parts that share that enable. The first is a free-running 20-bit time counter behind a programmable divider. The second is an alarm that fires when the counter steps onto an absolute value. The third is an interval timer that fires once every N slow ticks. Software reads the counter and sets up the alarm, divider and interval through a small word-addressed register bus. It reads a clear-on-read status word and controls an interrupt mask with separate set and clear write ports.

A tick driver configures the block in one of two ways. It can load the interval period to get a periodic tick. It can instead write the alarm to a future absolute counter value to get a one-shot event. In either case it takes the single level interrupt and reads the status word to acknowledge.

Top module: `sys_timer`

## Requirements
- R1: The time counter (read at word address 0) is 20 bits wide. It advances by exactly one on each divided step and wraps from 0xFFFFF to 0. A step that happens on a clock edge is visible on a read in the very next cycle.
- R2: The divider value P (read/write at word address 2, 16 bits, reset 32768) makes the counter step once every P slow ticks. P=1 and P=0 both step on every tick. A write to P restarts the division from zero.
- R3: Status bit 2 (time step) sets on every counter step.
- R4: Status bit 3 (alarm) sets when the counter steps onto the 20-bit alarm value (read/write at word address 1). Writing the alarm with the counter's present value does not fire until the counter wraps. A pending alarm bit stays set until the status word is read.
- R5: Status bit 0 (interval) sets once every N slow ticks, where N is the period (read/write at word address 3, 16 bits). N=0 disables it. A write to N restarts the interval count.
- R6: Reading the status word (word address 4) returns the pending bits and clears them. A status event on the same edge as the read stays pending. Bit 1 (watchdog placeholder) always reads 0.
- R7: A write to word address 5 sets every mask bit written as 1. A write to word address 6 clears every mask bit written as 1. Bits written as 0 keep their value. The mask reads back at word address 7.
- R8: The `irq` output is high exactly when some status bit is pending with its mask bit set.
- R9: After reset the counter is 0, the alarm is 0xFFFFF, the divider is 32768, the period is 0, and the status, mask and `irq` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slow_tick | input | 1 | One-cycle enable at the slow-clock rate |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed word, valid in the cycle of the access |
| irq | output | 1 | Level interrupt |

## Verification
A slow tick or a bus write takes effect on the clock edge that samples it. The counter, status, mask and `irq` therefore show the result in the cycle right after that edge. Read data is combinational, and the read's clear of the status word lands on the same edge. The bench drives every input at a falling edge and samples read data and `irq` one nanosecond later, half a period before the edge that acts on them. A read placed directly after a tick task therefore sees that tick's effect. Alarm and interval checks count ticks to the exact boundary: one tick short shows no bit, and the boundary tick shows it.

// File: rtl/st_pkg.sv
package st_pkg;

  localparam int ST_ADDR_W = 3;
  localparam int ST_NSTAT  = 4;

  // status bit positions
  localparam int SB_IVL = 0;
  localparam int SB_WDG = 1;
  localparam int SB_STEP = 2;
  localparam int SB_ALM = 3;

  typedef enum logic [ST_ADDR_W-1:0] {
    RA_COUNT  = 3'd0,
    RA_ALARM  = 3'd1,
    RA_DIV    = 3'd2,
    RA_PERIOD = 3'd3,
    RA_STATUS = 3'd4,
    RA_MSET   = 3'd5,
    RA_MCLR   = 3'd6,
    RA_MASK   = 3'd7
  } st_addr_e;

  // terminal index of a divide-by-n count; n of 0 behaves as 1
  function automatic logic [31:0] last_index(input logic [31:0] n);
    return (n == 32'd0) ? 32'd0 : n - 32'd1;
  endfunction

  // one step of a w-bit wrapping counter
  function automatic logic [31:0] wrap_inc(input logic [31:0] v, input int w);
    logic [32:0] full;
    full = ({1'b0, v} + 33'd1) & ((33'd1 << w) - 33'd1);
    return full[31:0];
  endfunction

endpackage

// File: rtl/st_ticker.sv
module st_ticker #(
  parameter int W           = 16,
  parameter bit ZERO_IS_OFF = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         restart,
  input  logic [W-1:0] limit,
  output logic         fire
);
  import st_pkg::*;

  logic [W-1:0] cnt_q;
  logic         live;
  logic         at_end;

  generate
    if (ZERO_IS_OFF) begin : g_gated
      assign live = (limit != '0);
    end else begin : g_always
      assign live = 1'b1;
    end
  endgenerate

  assign at_end = (32'(cnt_q) >= last_index(32'(limit)));
  assign fire   = tick && live && at_end && !restart;

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      cnt_q <= '0;
    end else if (tick && live) begin
      cnt_q <= at_end ? '0 : cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/st_rtc.sv
module st_rtc #(
  parameter int             CNT_W   = 20,
  parameter logic [CNT_W-1:0] ALM_RST = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             alm_we,
  input  logic [CNT_W-1:0] alm_wdata,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] alarm,
  output logic             alm_hit
);
  import st_pkg::*;

  logic [CNT_W-1:0] next_count;

  assign next_count = CNT_W'(wrap_inc(32'(count), CNT_W));
  assign alm_hit    = step && (next_count == alarm);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
    end else if (step) begin
      count <= next_count;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      alarm <= ALM_RST;
    end else if (alm_we) begin
      alarm <= alm_wdata;
    end
  end

endmodule

// File: rtl/st_irqctl.sv
module st_irqctl #(
  parameter int NB = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NB-1:0] set_vec,
  input  logic          rd_clr,
  input  logic          mset_we,
  input  logic          mclr_we,
  input  logic [NB-1:0] wbits,
  output logic [NB-1:0] status,
  output logic [NB-1:0] mask,
  output logic          irq
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status <= '0;
    end else begin
      status <= (rd_clr ? '0 : status) | set_vec;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask <= '0;
    end else if (mset_we) begin
      mask <= mask | wbits;
    end else if (mclr_we) begin
      mask <= mask & ~wbits;
    end
  end

  assign irq = |(status & mask);

endmodule

// File: rtl/sys_timer.sv
module sys_timer #(
  parameter int CNT_W   = 20,
  parameter int DIV_W   = 16,
  parameter int PER_W   = 16,
  parameter int DATA_W  = 32,
  parameter int DIV_RST = 32768
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       slow_tick,
  input  logic                       bus_sel,
  input  logic                       bus_we,
  input  logic [st_pkg::ST_ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0]          bus_wdata,
  output logic [DATA_W-1:0]          bus_rdata,
  output logic                       irq
);
  import st_pkg::*;

  localparam int NB = ST_NSTAT;

  st_addr_e         addr_e;
  logic             wr_acc;
  logic             rd_acc;
  logic             alm_we;
  logic             div_we;
  logic             per_we;
  logic             mset_we;
  logic             mclr_we;
  logic             stat_rd;
  logic [DIV_W-1:0] div_q;
  logic [PER_W-1:0] period_q;
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] alarm;
  logic             step_evt;
  logic             alm_evt;
  logic             ivl_evt;
  logic [NB-1:0]    set_vec;
  logic [NB-1:0]    status;
  logic [NB-1:0]    mask;
  logic [NB-1:0]    mask_bits;
  logic [DATA_W-1:0] rd_mux;
  logic             unused_wdata;

  // ---- bus decode ----
  assign addr_e  = st_addr_e'(bus_addr);
  assign wr_acc  = bus_sel && bus_we;
  assign rd_acc  = bus_sel && !bus_we;
  assign alm_we  = wr_acc && (addr_e == RA_ALARM);
  assign div_we  = wr_acc && (addr_e == RA_DIV);
  assign per_we  = wr_acc && (addr_e == RA_PERIOD);
  assign mset_we = wr_acc && (addr_e == RA_MSET);
  assign mclr_we = wr_acc && (addr_e == RA_MCLR);
  assign stat_rd = rd_acc && (addr_e == RA_STATUS);
  assign mask_bits = bus_wdata[NB-1:0];
  assign unused_wdata = ^bus_wdata;

  // ---- configuration registers ----
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q <= DIV_W'(DIV_RST);
    end else if (div_we) begin
      div_q <= bus_wdata[DIV_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      period_q <= '0;
    end else if (per_we) begin
      period_q <= bus_wdata[PER_W-1:0];
    end
  end

  // ---- time base ----
  st_ticker #(.W(DIV_W), .ZERO_IS_OFF(1'b0)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (slow_tick),
    .restart (div_we),
    .limit   (div_q),
    .fire    (step_evt)
  );

  st_rtc #(.CNT_W(CNT_W), .ALM_RST('1)) u_rtc (
    .clk       (clk),
    .rst_n     (rst_n),
    .step      (step_evt),
    .alm_we    (alm_we),
    .alm_wdata (bus_wdata[CNT_W-1:0]),
    .count     (count),
    .alarm     (alarm),
    .alm_hit   (alm_evt)
  );

  st_ticker #(.W(PER_W), .ZERO_IS_OFF(1'b1)) u_ivl (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (slow_tick),
    .restart (per_we),
    .limit   (period_q),
    .fire    (ivl_evt)
  );

  // ---- status and interrupt ----
  always_comb begin
    set_vec          = '0;
    set_vec[SB_IVL]  = ivl_evt;
    set_vec[SB_WDG]  = 1'b0;
    set_vec[SB_STEP] = step_evt;
    set_vec[SB_ALM]  = alm_evt;
  end

  st_irqctl #(.NB(NB)) u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (set_vec),
    .rd_clr  (stat_rd),
    .mset_we (mset_we),
    .mclr_we (mclr_we),
    .wbits   (mask_bits),
    .status  (status),
    .mask    (mask),
    .irq     (irq)
  );

  // ---- read mux ----
  always_comb begin
    rd_mux = '0;
    unique case (addr_e)
      RA_COUNT:  rd_mux = DATA_W'(count);
      RA_ALARM:  rd_mux = DATA_W'(alarm);
      RA_DIV:    rd_mux = DATA_W'(div_q);
      RA_PERIOD: rd_mux = DATA_W'(period_q);
      RA_STATUS: rd_mux = DATA_W'(status);
      RA_MASK:   rd_mux = DATA_W'(mask);
      default:   rd_mux = '0;
    endcase
  end

  assign bus_rdata = rd_acc ? rd_mux : '0;

endmodule

// File: rtl/st_checker.sv
module st_checker #(
  parameter int NB    = 4,
  parameter int CNT_W = 20,
  parameter int PER_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             step_evt,
  input logic             ivl_evt,
  input logic             stat_rd,
  input logic             mset_we,
  input logic [NB-1:0]    mask_bits,
  input logic [NB-1:0]    set_vec,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] alarm,
  input logic [PER_W-1:0] period_q,
  input logic [NB-1:0]    status,
  input logic [NB-1:0]    mask,
  input logic             irq
);

  assert_count_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    step_evt |=> count == CNT_W'($past(count) + 1'b1));

  assert_count_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !step_evt |=> $stable(count));

  assert_alarm_on_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[3]) |-> count == alarm);

  assert_interval_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ivl_evt |-> period_q != '0);

  assert_read_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && set_vec == '0) |=> status == '0);

  assert_wdog_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !status[1]);

  assert_mask_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mset_we |=> (mask & $past(mask_bits)) == $past(mask_bits));

  assert_irq_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mask == '0 |-> !irq);

endmodule

bind sys_timer st_checker #(.NB(NB), .CNT_W(CNT_W), .PER_W(PER_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .step_evt  (step_evt),
  .ivl_evt   (ivl_evt),
  .stat_rd   (stat_rd),
  .mset_we   (mset_we),
  .mask_bits (mask_bits),
  .set_vec   (set_vec),
  .count     (count),
  .alarm     (alarm),
  .period_q  (period_q),
  .status    (status),
  .mask      (mask),
  .irq       (irq)
);

// File: tb/test_sys_timer.sv
module test_sys_timer;

  localparam int OP_WR = 0;
  localparam int OP_RD = 1;
  localparam int OP_TK = 2;
  localparam int OP_IQ = 3;

  localparam logic [2:0] A_CNT = 3'd0, A_ALM = 3'd1, A_DIV = 3'd2, A_PER = 3'd3,
                         A_STA = 3'd4, A_SET = 3'd5, A_CLR = 3'd6, A_MSK = 3'd7;

  typedef struct packed {
    logic [1:0]  op;
    logic [2:0]  addr;
    logic [31:0] data;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 31;
  localparam vec_t TBL [NV] = '{
    '{2'(OP_WR), A_DIV, 32'd1,    4'd2},
    '{2'(OP_TK), A_CNT, 32'd5,    4'd1},
    '{2'(OP_RD), A_CNT, 32'd5,    4'd1},   // R1 one step per tick at divider 1
    '{2'(OP_RD), A_STA, 32'h4,    4'd3},   // R3 step bit
    '{2'(OP_RD), A_STA, 32'h0,    4'd6},   // R6 cleared by read
    '{2'(OP_WR), A_DIV, 32'd3,    4'd2},
    '{2'(OP_TK), A_CNT, 32'd6,    4'd2},
    '{2'(OP_RD), A_CNT, 32'd7,    4'd2},   // R2 divide by 3
    '{2'(OP_WR), A_DIV, 32'd1,    4'd2},
    '{2'(OP_WR), A_ALM, 32'd10,   4'd4},
    '{2'(OP_RD), A_STA, 32'h4,    4'd3},
    '{2'(OP_TK), A_CNT, 32'd2,    4'd4},
    '{2'(OP_RD), A_STA, 32'h4,    4'd4},   // R4 one short of alarm
    '{2'(OP_TK), A_CNT, 32'd1,    4'd4},
    '{2'(OP_RD), A_STA, 32'hC,    4'd4},   // R4 alarm at match
    '{2'(OP_RD), A_STA, 32'h0,    4'd6},
    '{2'(OP_WR), A_PER, 32'd4,    4'd5},
    '{2'(OP_TK), A_CNT, 32'd3,    4'd5},
    '{2'(OP_RD), A_STA, 32'h4,    4'd5},   // R5 one short of period
    '{2'(OP_TK), A_CNT, 32'd1,    4'd5},
    '{2'(OP_RD), A_STA, 32'h5,    4'd5},   // R5 interval bit
    '{2'(OP_WR), A_SET, 32'h9,    4'd7},
    '{2'(OP_RD), A_MSK, 32'h9,    4'd7},
    '{2'(OP_WR), A_SET, 32'h4,    4'd7},
    '{2'(OP_RD), A_MSK, 32'hD,    4'd7},   // R7 zero bits kept
    '{2'(OP_WR), A_CLR, 32'h1,    4'd7},
    '{2'(OP_RD), A_MSK, 32'hC,    4'd7},   // R7 clear
    '{2'(OP_TK), A_CNT, 32'd1,    4'd8},
    '{2'(OP_IQ), A_CNT, 32'd1,    4'd8},   // R8 masked step pending
    '{2'(OP_RD), A_STA, 32'h4,    4'd8},
    '{2'(OP_IQ), A_CNT, 32'd0,    4'd8}    // R8 low after read
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slow_tick = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int n_chk = 0;
  int n_err = 0;

  always #4 clk = ~clk;

  sys_timer i_sys_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .slow_tick (slow_tick),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // every task starts and ends just after a falling edge
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      slow_tick = 1'b1;
      @(negedge clk);
      slow_tick = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    logic [31:0] v;
    do_reset();

    // table walk
    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d step%0d", TBL[i].req, i);
      case (int'(TBL[i].op))
        OP_WR: wr(TBL[i].addr, TBL[i].data);
        OP_RD: begin rd(TBL[i].addr, v); check(tag, v, TBL[i].data); end
        OP_TK: ticks(int'(TBL[i].data));
        default: begin #1 check(tag, {31'd0, irq}, TBL[i].data); end
      endcase
    end

    // R9 reset values
    do_reset();
    rd(A_CNT, v); check("R9 counter", v, 32'd0);
    rd(A_ALM, v); check("R9 alarm", v, 32'hFFFFF);
    rd(A_DIV, v); check("R9 divider", v, 32'd32768);
    rd(A_PER, v); check("R9 period", v, 32'd0);
    rd(A_STA, v); check("R9 status", v, 32'd0);
    rd(A_MSK, v); check("R9 mask", v, 32'd0);
    #1 check("R9 irq", {31'd0, irq}, 32'd0);

    // R2 default divider: 10 ticks give no step
    ticks(10);
    rd(A_CNT, v); check("R2 default divider holds", v, 32'd0);

    // R4 alarm at present count must not fire; R5 period 0 stays off
    wr(A_DIV, 32'd0);
    ticks(3);
    rd(A_CNT, v); check("R2 divider zero acts as one", v, 32'd3);
    wr(A_ALM, 32'd3);
    rd(A_STA, v); check("R3 steps pending", v, 32'h4);
    ticks(4);
    rd(A_STA, v); check("R4 equal-to-count alarm silent, R5 off", v, 32'h4);

    // R4 pending alarm holds irq until read
    wr(A_ALM, 32'd9);
    wr(A_SET, 32'h8);
    ticks(2);
    #1 check("R8 alarm irq", {31'd0, irq}, 32'd1);
    ticks(1);
    #1 check("R4 alarm stays pending", {31'd0, irq}, 32'd1);
    rd(A_STA, v); check("R4 alarm status", v, 32'hC);
    #1 check("R6 irq after clear", {31'd0, irq}, 32'd0);

    // R6 event on the same edge as the status read stays pending
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = A_STA; slow_tick = 1'b1;
    #1 check("R6 read before step", bus_rdata, 32'h0);
    @(negedge clk);
    bus_sel = 1'b0; slow_tick = 1'b0;
    rd(A_STA, v); check("R6 concurrent step kept", v, 32'h4);
    rd(A_CNT, v); check("R1 count after steps", v, 32'd11);

    summary();
  end

endmodule